// File: doc/BRIEF.md
# Variable-Page TLB Translation Lookup

This block is the lookup half of a fully associative translation buffer. A 32-bit virtual address, the current process ID and the privilege mode go in. Every stored entry is compared in parallel. The block returns whether an entry matched, which entry won, the translated physical address, and the read, write and execute rights for the access.

Each entry has its own page size, chosen from eight sizes between 1 KiB and 16 MiB. An entry can be private to one process ID, or global when its ID is zero. The rights stored in an entry pass through a zone protection word. Depending on the zone and on the privilege mode, that word can revoke the rights or widen them.

Entries are loaded one at a time through a write port, and a reset invalidates all of them. A parameter selects whether the result is registered or combinational.

Top module: `vp_tlb_lookup`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss until entries are written.
- R2: The tag word holds the page number in bits [31:10] and a size code in bits [9:7]. The page size is 1 KiB × 4^code. An entry matches when the virtual address and the tag agree on every bit at or above log2(page size).
- R3: An entry takes part in matching only while tag bit 6 (valid) is set. Rewriting an entry with bit 6 clear removes it from lookups.
- R4: A nonzero 8-bit entry ID matches only when it equals `pid_i`. An ID of zero matches any `pid_i`.
- R5: When several entries match, the one with the lowest index wins and its index appears on `idx_o`.
- R6: The physical address takes the data word bits above the page size and the virtual address bits below it. The result is then ANDed with the parameter `PA_MASK`. Data bits [9:0] never reach the address.
- R7: Data word bits [7:4] select a zone z. The 2-bit zone field is `zpr_i[31-2z:30-2z]`. The field is taken as 01 when z exceeds `ZONE_MAX` or when `ZONES_EN` is 0.
- R8: With zone field 01, and with field 00 in supervisor mode, a hit grants read. Write follows data bit 8 and execute follows data bit 9.
- R9: With zone field 00 in user mode (`user_i`=1), a hit still reports hit, index and address, but read, write and execute are all 0.
- R10: Zone field 11 grants read, write and execute in either mode. Field 10 grants all three in supervisor mode and behaves as 01 in user mode.
- R11: On a miss, `hit_o`, `idx_o`, `pa_o` and all three rights are 0.
- R12: With `REG_OUT`=1 the outputs show the lookup of the inputs present at the previous rising clock edge. With `REG_OUT`=0 they follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, invalidates all entries |
| wr_en_i | input | 1 | Write one entry this cycle |
| wr_idx_i | input | IDX_W | Entry index to write |
| wr_tag_i | input | 32 | Tag word: page number, size code, valid |
| wr_data_i | input | 32 | Data word: real page, execute, write, zone |
| wr_tid_i | input | 8 | Entry ID, zero for global |
| va_i | input | 32 | Virtual address to translate |
| pid_i | input | 8 | Current process ID |
| user_i | input | 1 | 1 for user mode, 0 for supervisor |
| zpr_i | input | 32 | Zone protection word, two bits per zone |
| hit_o | output | 1 | An entry matched |
| idx_o | output | IDX_W | Index of the winning entry |
| pa_o | output | 32 | Physical address |
| rd_o | output | 1 | Read allowed |
| wr_o | output | 1 | Write allowed |
| ex_o | output | 1 | Execute allowed |

## Verification
The bench builds the block with eight entries, `ZONE_MAX`=11, `PA_MASK`=0x0FFF_FFFF and `REG_OUT`=1. The small `ZONE_MAX` lets an entry select zone 13, which exercises the out-of-range fallback to field 01. The narrowed mask lets a real page number with bit 28 set show the masking on the physical address. Overlapping 4 KiB entries with private and global IDs exercise lowest-index priority and ID filtering. A 1 MiB entry and a 1 KiB entry are probed at the last byte inside the page and at the first byte past it. The registered output stage lets the bench confirm that the outputs lag the inputs by exactly one edge.

// File: rtl/vp_tlb_pkg.sv
package vp_tlb_pkg;

    localparam int TAG_VALID_BIT = 6;
    localparam int DATA_WR_BIT   = 8;
    localparam int DATA_EX_BIT   = 9;

    typedef struct packed {
        logic [31:0] tag;
        logic [31:0] data;
        logic [7:0]  tid;
    } tlb_ent_t;

    // Bits below the page boundary for a 3-bit size code (1 KiB * 4^code).
    function automatic logic [31:0] page_low_mask(input logic [2:0] code);
        logic [4:0] sh;
        sh = 5'd10 + {1'b0, code, 1'b0};
        return (32'd1 << sh) - 32'd1;
    endfunction

endpackage

// File: rtl/vp_tlb_store.sv
module vp_tlb_store
    import vp_tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  tlb_ent_t         wr_ent_i,
    output tlb_ent_t         ent_o [ENTRIES]
);

    tlb_ent_t mem_d [ENTRIES];
    tlb_ent_t mem_q [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            mem_d[i] = mem_q[i];
            if (wr_en_i && (int'(wr_idx_i) == i)) begin
                mem_d[i] = wr_ent_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            ent_o[i] = mem_q[i];
        end
    end

    // R3
    store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (int'(wr_idx_i) < ENTRIES)) |=>
            (mem_q[$past(wr_idx_i)].tag == $past(wr_ent_i.tag)));

endmodule

// File: rtl/vp_tlb_match_row.sv
module vp_tlb_match_row
    import vp_tlb_pkg::*;
(
    input  tlb_ent_t    ent_i,
    input  logic [31:0] va_i,
    input  logic [7:0]  pid_i,
    output logic        match_o
);

    logic [31:0] hi_mask;
    logic        page_eq;
    logic        id_ok;

    always_comb begin
        hi_mask = ~page_low_mask(ent_i.tag[9:7]);
        page_eq = ((va_i & hi_mask) == (ent_i.tag & hi_mask));
        id_ok   = (ent_i.tid == 8'd0) || (ent_i.tid == pid_i);
        match_o = ent_i.tag[TAG_VALID_BIT] && page_eq && id_ok;
    end

endmodule

// File: rtl/vp_tlb_zone_perm.sv
module vp_tlb_zone_perm #(
    parameter int ZONE_MAX = 15,
    parameter bit ZONES_EN = 1'b1
) (
    input  logic [3:0]  zsel_i,
    input  logic [31:0] zpr_i,
    input  logic        user_i,
    input  logic        ent_w_i,
    input  logic        ent_x_i,
    output logic        rd_o,
    output logic        wr_o,
    output logic        ex_o
);

    logic [31:0] shifted;
    logic [1:0]  fld;

    always_comb begin
        // field for zone z sits at bit 30-2z = 2*(15-z)
        shifted = zpr_i >> {~zsel_i, 1'b0};
        fld     = shifted[1:0];
        if (!ZONES_EN || (int'(zsel_i) > ZONE_MAX)) begin
            fld = 2'b01;
        end
        rd_o = 1'b1;
        wr_o = ent_w_i;
        ex_o = ent_x_i;
        unique case (fld)
            2'b00: begin
                if (user_i) begin
                    rd_o = 1'b0;
                    wr_o = 1'b0;
                    ex_o = 1'b0;
                end
            end
            2'b01: ;
            2'b10: begin
                if (!user_i) begin
                    wr_o = 1'b1;
                    ex_o = 1'b1;
                end
            end
            2'b11: begin
                wr_o = 1'b1;
                ex_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/vp_tlb_lookup.sv
module vp_tlb_lookup
    import vp_tlb_pkg::*;
#(
    parameter int          ENTRIES  = 16,
    parameter int          ZONE_MAX = 15,
    parameter bit          ZONES_EN = 1'b1,
    parameter logic [31:0] PA_MASK  = 32'hFFFF_FFFF,
    parameter bit          REG_OUT  = 1'b1,
    localparam int         IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [31:0]      wr_tag_i,
    input  logic [31:0]      wr_data_i,
    input  logic [7:0]       wr_tid_i,
    input  logic [31:0]      va_i,
    input  logic [7:0]       pid_i,
    input  logic             user_i,
    input  logic [31:0]      zpr_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [31:0]      pa_o,
    output logic             rd_o,
    output logic             wr_o,
    output logic             ex_o
);

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic [31:0]      pa;
        logic             rd;
        logic             wr;
        logic             ex;
    } res_t;

    tlb_ent_t         ents [ENTRIES];
    tlb_ent_t         wr_ent;
    logic [ENTRIES-1:0] match_vec;
    logic             sel_hit;
    logic [IDX_W-1:0] sel_idx;
    tlb_ent_t         sel_ent;
    logic [31:0]      low_m;
    logic             z_rd, z_wr, z_ex;
    res_t             res_d, res_q;

    assign wr_ent = '{tag: wr_tag_i, data: wr_data_i, tid: wr_tid_i};

    vp_tlb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .wr_idx_i (wr_idx_i),
        .wr_ent_i (wr_ent),
        .ent_o    (ents)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_row
        vp_tlb_match_row row_i (
            .ent_i   (ents[g]),
            .va_i    (va_i),
            .pid_i   (pid_i),
            .match_o (match_vec[g])
        );
    end

    // lowest index wins
    always_comb begin
        sel_hit = 1'b0;
        sel_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                sel_hit = 1'b1;
                sel_idx = IDX_W'(i);
            end
        end
        sel_ent = ents[sel_idx];
        low_m   = page_low_mask(sel_ent.tag[9:7]);
    end

    vp_tlb_zone_perm #(.ZONE_MAX(ZONE_MAX), .ZONES_EN(ZONES_EN)) zone_i (
        .zsel_i  (sel_ent.data[7:4]),
        .zpr_i   (zpr_i),
        .user_i  (user_i),
        .ent_w_i (sel_ent.data[DATA_WR_BIT]),
        .ent_x_i (sel_ent.data[DATA_EX_BIT]),
        .rd_o    (z_rd),
        .wr_o    (z_wr),
        .ex_o    (z_ex)
    );

    always_comb begin
        res_d = '0;
        if (sel_hit) begin
            res_d.hit = 1'b1;
            res_d.idx = sel_idx;
            res_d.pa  = ((sel_ent.data & ~low_m) | (va_i & low_m)) & PA_MASK;
            res_d.rd  = z_rd;
            res_d.wr  = z_wr;
            res_d.ex  = z_ex;
        end
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            res_q <= res_d;
        end

        // R12
        out_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ##1 (hit_o == $past(res_d.hit)) && (pa_o == $past(res_d.pa)));
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign hit_o = res_q.hit;
    assign idx_o = res_q.idx;
    assign pa_o  = res_q.pa;
    assign rd_o  = res_q.rd;
    assign wr_o  = res_q.wr;
    assign ex_o  = res_q.ex;

    // R5
    win_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hit |-> (match_vec[sel_idx] &&
                     ((match_vec & ((ENTRIES'(1) << sel_idx) - ENTRIES'(1))) == '0)));

    // R11
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (pa_o == 32'd0 && idx_o == '0 && !rd_o && !wr_o && !ex_o));

    // R9
    rights_need_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o || ex_o) |-> (rd_o && hit_o));

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (match_vec == '0));

endmodule

// File: tb/vp_tlb_lookup_tb.sv
module vp_tlb_lookup_tb_top;

    localparam int CLK_PER = 10;
    localparam int NV      = 15;

    typedef struct packed {
        logic [31:0] va;
        logic [7:0]  pid;
        logic        user;
        logic [31:0] zpr;
        logic        hit;
        logic [2:0]  idx;
        logic [31:0] pa;
        logic [2:0]  rwx;
    } vec_t;

    // entries: e0 4K pid5 zone1 W; e1 1M global zone2 X; e2 4K pid7 zone0 WX;
    // e3 4K global zone13 none; e4 16M invalid; e5 1K global zone3 W
    localparam vec_t VECS [NV] = '{
        '{32'h0001_0ABC, 8'h05, 1'b1, 32'h1000_0000, 1'b1, 3'd0, 32'h0080_0ABC, 3'b110},
        '{32'h0001_0ABC, 8'h05, 1'b1, 32'h0000_0000, 1'b1, 3'd0, 32'h0080_0ABC, 3'b000},
        '{32'h0001_0ABC, 8'h05, 1'b0, 32'h0000_0000, 1'b1, 3'd0, 32'h0080_0ABC, 3'b110},
        '{32'h0001_0ABC, 8'h05, 1'b0, 32'h2000_0000, 1'b1, 3'd0, 32'h0080_0ABC, 3'b111},
        '{32'h0001_0ABC, 8'h05, 1'b1, 32'h2000_0000, 1'b1, 3'd0, 32'h0080_0ABC, 3'b110},
        '{32'h0001_0ABC, 8'h05, 1'b1, 32'h3000_0000, 1'b1, 3'd0, 32'h0080_0ABC, 3'b111},
        '{32'h0001_0FFF, 8'h07, 1'b0, 32'h0000_0000, 1'b1, 3'd2, 32'h0090_0FFF, 3'b111},
        '{32'h0001_0004, 8'h09, 1'b1, 32'h0000_0000, 1'b1, 3'd3, 32'h00A0_0004, 3'b100},
        '{32'h002A_BCDE, 8'h33, 1'b1, 32'h0400_0000, 1'b1, 3'd1, 32'h023A_BCDE, 3'b101},
        '{32'h002F_FFFF, 8'h33, 1'b1, 32'h0400_0000, 1'b1, 3'd1, 32'h023F_FFFF, 3'b101},
        '{32'h0030_0000, 8'h33, 1'b1, 32'h0400_0000, 1'b0, 3'd0, 32'h0000_0000, 3'b000},
        '{32'h0400_0000, 8'h00, 1'b0, 32'hFFFF_FFFF, 1'b0, 3'd0, 32'h0000_0000, 3'b000},
        '{32'h0000_37FF, 8'h00, 1'b0, 32'h0100_0000, 1'b1, 3'd5, 32'h0000_5BFF, 3'b110},
        '{32'h0000_3800, 8'h00, 1'b0, 32'h0100_0000, 1'b0, 3'd0, 32'h0000_0000, 3'b000},
        '{32'h0001_0000, 8'h06, 1'b1, 32'h0000_0000, 1'b1, 3'd3, 32'h00A0_0000, 3'b100}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [31:0] wr_tag, wr_data;
    logic [7:0]  wr_tid;
    logic [31:0] va;
    logic [7:0]  pid;
    logic        user;
    logic [31:0] zpr;
    logic        hit, rd, wr, ex;
    logic [2:0]  idx;
    logic [31:0] pa;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PER / 2) clk = ~clk;

    vp_tlb_lookup #(
        .ENTRIES(8), .ZONE_MAX(11), .ZONES_EN(1'b1),
        .PA_MASK(32'h0FFF_FFFF), .REG_OUT(1'b1)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_tag_i(wr_tag),
        .wr_data_i(wr_data), .wr_tid_i(wr_tid),
        .va_i(va), .pid_i(pid), .user_i(user), .zpr_i(zpr),
        .hit_o(hit), .idx_o(idx), .pa_o(pa), .rd_o(rd), .wr_o(wr), .ex_o(ex)
    );

    function automatic string vtag(input int i);
        case (i)
            0, 2:        return "R8";
            1:           return "R9";
            3, 4, 5:     return "R10";
            6:           return "R4";
            7, 14:       return "R7";
            8, 9:        return "R6";
            10, 12, 13:  return "R2";
            11:          return "R3";
            default:     return "R5";
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic put_ent(input logic [2:0] i, input logic [31:0] t,
                           input logic [31:0] d, input logic [7:0] id);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = i; wr_tag = t; wr_data = d; wr_tid = id;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drive(input vec_t v);
        va = v.va; pid = v.pid; user = v.user; zpr = v.zpr;
    endtask

    task automatic chk_vec(input string tag, input vec_t v);
        chk(tag, "hit", 32'(hit), 32'(v.hit));
        chk(tag, "idx", 32'(idx), 32'(v.idx));
        chk(tag, "pa",  pa, v.pa);
        chk(tag, "rwx", 32'({rd, wr, ex}), 32'(v.rwx));
    endtask

    initial begin
        vec_t v;
        rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_tag = '0; wr_data = '0; wr_tid = '0;
        va = '0; pid = '0; user = 1'b0; zpr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        drive(VECS[0]);
        @(negedge clk);
        chk("R1", "hit after reset", 32'(hit), 32'd0);

        put_ent(3'd0, 32'h0001_00C0, 32'h0080_0110, 8'h05);
        put_ent(3'd1, 32'h0020_02C0, 32'h1230_0220, 8'h00);
        put_ent(3'd2, 32'h0001_00C0, 32'h0090_0300, 8'h07);
        put_ent(3'd3, 32'h0001_00C0, 32'h00A0_00D0, 8'h00);
        put_ent(3'd4, 32'h0400_0380, 32'h0F00_0330, 8'h00);
        put_ent(3'd5, 32'h0000_3440, 32'h0000_5930, 8'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(negedge clk);
            chk_vec(vtag(i), VECS[i]);
        end

        // R5: e0 and e3 overlap for pid 5; e0 wins first
        @(negedge clk);
        drive(VECS[0]);
        @(negedge clk);
        chk("R5", "idx overlap", 32'(idx), 32'd0);

        // R12: output lags by one edge
        drive(VECS[10]);
        @(negedge clk);
        drive(VECS[0]);
        #1;
        chk("R12", "hit before edge", 32'(hit), 32'd0);
        @(negedge clk);
        chk("R12", "hit after edge", 32'(hit), 32'd1);

        // R3: invalidate e0, global e3 now wins for pid 5
        put_ent(3'd0, 32'h0001_0080, 32'h0080_0110, 8'h05);
        drive(VECS[0]);
        @(negedge clk);
        @(negedge clk);
        chk("R3", "idx after invalidate", 32'(idx), 32'd3);
        chk("R3", "pa after invalidate", pa, 32'h00A0_0ABC);

        // R1: reset clears everything
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        v = VECS[8];
        drive(v);
        @(negedge clk);
        chk("R1", "hit after second reset", 32'(hit), 32'd0);
        chk("R11", "pa on miss", pa, 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PER * 20000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule